// File: doc/BRIEF.md
# Two-Level Gated Interrupt Aggregator

This block collects event pulses from eleven sources into one active-high interrupt output. The sources are arranged as two cascaded groups. The lower group has six event inputs, a sticky status register and a per-bit enable register. The enable register also carries a master gate. The gated and ORed result of the lower group sets one status bit of the upper group. The upper group takes five further event inputs, so it also has six sources. It has its own status and enable registers.

The ORed, enabled upper-group status drives the output through a hold stage. The hold stage follows its input while the pin-enable bit in the configuration register is 1. It keeps its last value while that bit is 0. To silence the output safely, software runs three steps in order: it confirms that pin-enable is set, clears every upper-group status bit, and then clears pin-enable. After that the stage holds a low level.

Software reaches the five registers through a plain synchronous port with word addresses. Reads return data one cycle after they are issued. Status bits are write-one-to-clear. All registers reset to zero, so both the master gate and pin-enable start closed.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset all five registers read 0 and `irq_o` is 0.
- R2: A 1 on `sub_evt[i]` at a clock edge sets lower-group status bit i (address 2, bits 5:0). Writing 1 to a status bit clears it. An event in the same cycle as its clear wins, so the bit stays 1.
- R3: The lower group drives the cascade bit only when (status AND enable) is non-zero and the master gate is 1. The enable register is at address 3, with enables in bits 5:0 and the master gate in bit 31. The cascade bit is upper-group status bit 5. It is set at the edge after that condition holds, and a clear loses while the condition still holds.
- R4: A 1 on `top_evt[j]` sets upper-group status bit j (address 0, bits 4:0). These bits clear on a write of 1, and an event has priority over a clear in the same cycle.
- R5: While pin-enable (address 4, bit 0) is 1, `irq_o` at each edge takes the OR of upper status AND upper enable (address 1, bits 5:0) as it stood before that edge. A disabled source never raises `irq_o`.
- R6: While pin-enable is 0, `irq_o` keeps its value. This holds even when status changes or is cleared.
- R7: A read issued at one edge presents its data on `reg_rdata` after that edge and holds it until the next read. Unimplemented bits and addresses 5 to 7 read 0.
- R8: The three-step disable sequence leaves `irq_o` at 0, and later events do not raise it until pin-enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe for one cycle |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| sub_evt | input | 6 | Lower-group event pulses |
| top_evt | input | 5 | Upper-group direct event pulses |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
An upper-group event captured at edge E raises `irq_o` after edge E+1. A lower-group event takes one more edge, E+2, because it passes through the cascade bit. A status clear shows on the pin one edge after the write, and read data appears one edge after the strobe. The bench drives and samples on falling edges. It checks the pin at every intermediate step, so a result that arrives one cycle early or one cycle late is a mismatch.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned NSRC        = 6;
  localparam int unsigned DW          = 32;
  localparam int unsigned AW          = 3;
  localparam int unsigned NDIRECT     = NSRC - 1;
  localparam int unsigned GATE_BIT    = 31;
  localparam int unsigned PIN_EN_BIT  = 0;
  localparam int unsigned CASCADE_BIT = NSRC - 1;

  typedef enum logic [AW-1:0] {
    ADR_UP_STAT  = 3'd0,
    ADR_UP_EN    = 3'd1,
    ADR_LO_STAT  = 3'd2,
    ADR_LO_EN    = 3'd3,
    ADR_CFG      = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned N        = 6,
  parameter bit          HAS_GATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         stat_we,
  input  logic         en_we,
  input  logic [N-1:0] wmask,
  input  logic         wgate,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] en_o,
  output logic         gate_o,
  output logic         any_o
);
  logic [N-1:0] stat_q, en_q, clr_mask;

  assign clr_mask = stat_we ? wmask : '0;

  // Clear first, then let a new event win
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= wmask;
  end

  generate
    if (HAS_GATE) begin : g_gate
      logic gate_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     gate_q <= 1'b0;
        else if (en_we) gate_q <= wgate;
      end
      assign gate_o = gate_q;
    end else begin : g_nogate
      assign gate_o = 1'b1;
    end
  endgenerate

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign any_o  = (|(stat_q & en_q)) & gate_o;
endmodule

// File: rtl/irq_pin_hold.sv
module irq_pin_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_pin_en,
  input  logic level_i,
  output logic pin_en_o,
  output logic irq_o
);
  logic pin_en_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_en_q <= 1'b0;
    else if (cfg_we) pin_en_q <= cfg_pin_en;
  end

  // Transparent-latch model: follows while enabled, freezes otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= 1'b0;
    else if (pin_en_q) hold_q <= level_i;
  end

  assign pin_en_o = pin_en_q;
  assign irq_o    = hold_q;
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_cascade_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output logic          up_stat_we,
  output logic          up_en_we,
  output logic          lo_stat_we,
  output logic          lo_en_we,
  output logic          cfg_we,
  input  logic [N-1:0]  up_stat,
  input  logic [N-1:0]  up_en,
  input  logic [N-1:0]  lo_stat,
  input  logic [N-1:0]  lo_en,
  input  logic          lo_gate,
  input  logic          pin_en,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_word, rdata_q;

  assign up_stat_we = wr && (addr == ADR_UP_STAT);
  assign up_en_we   = wr && (addr == ADR_UP_EN);
  assign lo_stat_we = wr && (addr == ADR_LO_STAT);
  assign lo_en_we   = wr && (addr == ADR_LO_EN);
  assign cfg_we     = wr && (addr == ADR_CFG);

  always_comb begin
    rd_word = '0;
    unique case (addr)
      ADR_UP_STAT: rd_word[N-1:0] = up_stat;
      ADR_UP_EN:   rd_word[N-1:0] = up_en;
      ADR_LO_STAT: rd_word[N-1:0] = lo_stat;
      ADR_LO_EN: begin
        rd_word[N-1:0]  = lo_en;
        rd_word[GATE_BIT] = lo_gate;
      end
      ADR_CFG:     rd_word[PIN_EN_BIT] = pin_en;
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_word;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      reg_addr,
  input  logic               reg_wr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               reg_rd,
  output logic [DW-1:0]      reg_rdata,
  input  logic [NSRC-1:0]    sub_evt,
  input  logic [NDIRECT-1:0] top_evt,
  output logic               irq_o
);
  logic up_stat_we, up_en_we, lo_stat_we, lo_en_we, cfg_we;
  logic [NSRC-1:0] lo_stat, lo_en, up_stat, up_en, up_evt;
  logic lo_gate, lo_any, up_gate, up_any, pin_en;

  irq_reg_decode #(.N(NSRC)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .up_stat_we(up_stat_we), .up_en_we(up_en_we),
    .lo_stat_we(lo_stat_we), .lo_en_we(lo_en_we), .cfg_we(cfg_we),
    .up_stat(up_stat), .up_en(up_en), .lo_stat(lo_stat), .lo_en(lo_en),
    .lo_gate(lo_gate), .pin_en(pin_en), .rdata(reg_rdata)
  );

  irq_src_bank #(.N(NSRC), .HAS_GATE(1'b1)) u_lower (
    .clk(clk), .rst_n(rst_n), .evt_i(sub_evt),
    .stat_we(lo_stat_we), .en_we(lo_en_we),
    .wmask(reg_wdata[NSRC-1:0]), .wgate(reg_wdata[GATE_BIT]),
    .stat_o(lo_stat), .en_o(lo_en), .gate_o(lo_gate), .any_o(lo_any)
  );

  // Cascade input occupies the top bit of the upper group
  assign up_evt = {lo_any, top_evt};

  irq_src_bank #(.N(NSRC), .HAS_GATE(1'b0)) u_upper (
    .clk(clk), .rst_n(rst_n), .evt_i(up_evt),
    .stat_we(up_stat_we), .en_we(up_en_we),
    .wmask(reg_wdata[NSRC-1:0]), .wgate(1'b0),
    .stat_o(up_stat), .en_o(up_en), .gate_o(up_gate), .any_o(up_any)
  );

  irq_pin_hold u_pin (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_pin_en(reg_wdata[PIN_EN_BIT]), .level_i(up_any),
    .pin_en_o(pin_en), .irq_o(irq_o)
  );
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_rd,
  input logic [DW-1:0]      reg_rdata,
  input logic [NSRC-1:0]    sub_evt,
  input logic [NDIRECT-1:0] top_evt,
  input logic [NSRC-1:0]    lo_stat,
  input logic [NSRC-1:0]    up_stat,
  input logic               lo_any,
  input logic               up_any,
  input logic               pin_en,
  input logic               irq_o
);
  assert_evt_sets_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_evt != '0) |=> ((lo_stat & $past(sub_evt)) == $past(sub_evt)));

  assert_cascade_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_any |=> up_stat[CASCADE_BIT]);

  assert_evt_sets_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (top_evt != '0) |=> ((up_stat[NDIRECT-1:0] & $past(top_evt)) == $past(top_evt)));

  assert_pin_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_en |=> (irq_o == $past(up_any)));

  assert_pin_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |=> $stable(irq_o));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind irq_cascade_ctrl irq_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .sub_evt(sub_evt), .top_evt(top_evt), .lo_stat(lo_stat), .up_stat(up_stat),
  .lo_any(lo_any), .up_any(up_any), .pin_en(pin_en), .irq_o(irq_o)
);

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_UST = 3'd0, A_UEN = 3'd1, A_LST = 3'd2,
                         A_LEN = 3'd3, A_CFG = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [5:0]  sub_evt = '0;
  logic [4:0]  top_evt = '0;
  logic        irq_o;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cascade_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .sub_evt(sub_evt), .top_evt(top_evt), .irq_o(irq_o)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    reg_addr = a; reg_rd = 1'b1;
    step();
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse_top(logic [4:0] m);
    top_evt = m; step(); top_evt = '0;
  endtask

  task automatic pulse_sub(logic [5:0] m);
    sub_evt = m; step(); sub_evt = '0;
  endtask

  task automatic t_reset();
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    rd_chk("R1 up_stat", A_UST, 32'd0);
    rd_chk("R1 up_en",   A_UEN, 32'd0);
    rd_chk("R1 lo_stat", A_LST, 32'd0);
    rd_chk("R1 lo_en",   A_LEN, 32'd0);
    rd_chk("R1 cfg",     A_CFG, 32'd0);
  endtask

  task automatic t_primary();
    wr(A_CFG, 32'd1);
    wr(A_UEN, 32'h4);
    pulse_top(5'h01);
    check("R5 disabled src", {31'd0, irq_o}, 32'd0);
    step();
    check("R5 disabled src later", {31'd0, irq_o}, 32'd0);
    rd_chk("R4 status set", A_UST, 32'h1);
    pulse_top(5'h04);
    check("R5 not early", {31'd0, irq_o}, 32'd0);
    step();
    check("R5 raised", {31'd0, irq_o}, 32'd1);
    wr(A_UST, 32'h5);
    check("R5 held one edge", {31'd0, irq_o}, 32'd1);
    step();
    check("R5 dropped", {31'd0, irq_o}, 32'd0);
    rd_chk("R4 w1c", A_UST, 32'd0);
  endtask

  task automatic t_priority();
    reg_addr = A_UST; reg_wdata = 32'h8; reg_wr = 1'b1; top_evt = 5'h08;
    step();
    reg_wr = 1'b0; top_evt = '0;
    rd_chk("R4 event beats clear", A_UST, 32'h8);
    wr(A_UST, 32'h8);
    rd_chk("R4 cleared", A_UST, 32'd0);
    reg_addr = A_LST; reg_wdata = 32'h10; reg_wr = 1'b1; sub_evt = 6'h10;
    step();
    reg_wr = 1'b0; sub_evt = '0;
    rd_chk("R2 event beats clear", A_LST, 32'h10);
    wr(A_LST, 32'h10);
    rd_chk("R2 cleared", A_LST, 32'd0);
  endtask

  task automatic t_secondary();
    wr(A_UEN, 32'h20);
    wr(A_LEN, 32'h2);
    pulse_sub(6'h02);
    for (int i = 0; i < 3; i++) begin
      check("R3 no master", {31'd0, irq_o}, 32'd0);
      step();
    end
    rd_chk("R3 cascade idle", A_UST, 32'd0);
    rd_chk("R2 status set", A_LST, 32'h2);
    wr(A_LEN, 32'h8000_0002);
    check("R3 edge+0", {31'd0, irq_o}, 32'd0);
    step();
    check("R3 edge+1", {31'd0, irq_o}, 32'd0);
    step();
    check("R3 edge+2", {31'd0, irq_o}, 32'd1);
    rd_chk("R7 gate readback", A_LEN, 32'h8000_0002);
    wr(A_UST, 32'h20);
    rd_chk("R3 clear loses", A_UST, 32'h20);
    wr(A_LST, 32'h2);
    wr(A_UST, 32'h20);
    check("R3 pin held", {31'd0, irq_o}, 32'd1);
    step();
    check("R3 pin low", {31'd0, irq_o}, 32'd0);
    rd_chk("R3 cascade cleared", A_UST, 32'd0);
    wr(A_LEN, 32'd0);
    wr(A_UEN, 32'h4);
  endtask

  task automatic t_freeze();
    pulse_top(5'h04);
    step();
    check("R6 pre", {31'd0, irq_o}, 32'd1);
    wr(A_CFG, 32'd0);
    wr(A_UST, 32'h4);
    for (int i = 0; i < 3; i++) begin
      check("R6 frozen high", {31'd0, irq_o}, 32'd1);
      step();
    end
    rd_chk("R6 cfg", A_CFG, 32'd0);
    rd_chk("R6 status clear", A_UST, 32'd0);
    wr(A_CFG, 32'd1);
    check("R6 still held", {31'd0, irq_o}, 32'd1);
    step();
    check("R6 released", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_safe_disable();
    pulse_top(5'h04);
    step();
    check("R8 active", {31'd0, irq_o}, 32'd1);
    rd_chk("R8 step1 pin enabled", A_CFG, 32'd1);
    wr(A_UST, 32'h3F);
    step();
    check("R8 step2 low", {31'd0, irq_o}, 32'd0);
    wr(A_CFG, 32'd0);
    pulse_top(5'h04);
    for (int i = 0; i < 3; i++) begin
      check("R8 stays low", {31'd0, irq_o}, 32'd0);
      step();
    end
    rd_chk("R8 event recorded", A_UST, 32'h4);
    wr(A_CFG, 32'd1);
    check("R8 reenable edge+0", {31'd0, irq_o}, 32'd0);
    step();
    check("R8 reenable edge+1", {31'd0, irq_o}, 32'd1);
    wr(A_UST, 32'h4);
    step();
    step();
  endtask

  task automatic t_map();
    logic [31:0] v;
    for (int a = 5; a < 8; a++) rd_chk("R7 hole", 3'(a), 32'd0);
    wr(A_UEN, 32'hFFFF_FFFF);
    rd_chk("R7 up_en bits", A_UEN, 32'h3F);
    wr(A_UEN, 32'd0);
    wr(A_LEN, 32'hFFFF_FFFF);
    rd(A_LEN, v);
    check("R7 lo_en bits", v, 32'h8000_003F);
    step();
    step();
    check("R7 rdata held", reg_rdata, 32'h8000_003F);
    wr(A_LEN, 32'd0);
    wr(A_CFG, 32'hFFFF_FFFF);
    rd_chk("R7 cfg bits", A_CFG, 32'd1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_primary();
    t_priority();
    t_secondary();
    t_freeze();
    t_safe_disable();
    t_map();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule